// File: doc/BRIEF.md
# Display Memory Address Pointer

This block keeps the current column and bank address for a display memory of 102 columns by 65 rows, held as nine banks: banks 0 to 7 carry one byte per column and bank 8 carries a single bit per column. A host-side command decoder loads the column (X) and bank (Y) registers directly and pulses a read or write strobe for each data byte. After a strobe, the pointer moves to the next address in the chosen scan order.

Two scan orders exist. In row-major order, X advances first and Y steps when X wraps. In column-major order, Y advances first and X steps when Y wraps. The addressing mode is a two-state machine with states ST_HORIZ and ST_VERT. A configuration write with `cfg_vert` high takes the HORIZ_TO_VERT transition. A configuration write with `cfg_vert` low takes the VERT_TO_HORIZ transition. Any other cycle holds the state (HOLD).

The same configuration write also stores a column-mirror flag and a read-modify-write flag. The mirror flag maps logical columns onto physical columns in reverse order. The read-modify-write flag stops reads from moving the pointer. The block also drives a per-bank data mask and flags any load value that is out of range.

Top module: `disp_addr_ptr`

## Requirements
- R1: After reset, cur_x=0, cur_y=0, load_err=0, the mode is ST_HORIZ, and both the mirror flag and the read-modify-write flag are 0.
- R2: In ST_HORIZ, each advance raises X by 1 and leaves Y unchanged. From X=101, an advance sets X to 0 and raises Y by 1.
- R3: In ST_VERT, each advance raises Y by 1 and leaves X unchanged. From Y=8, an advance sets Y to 0 and raises X by 1.
- R4: From (X=101, Y=8), an advance goes to (0,0) in either mode.
- R5: With the read-modify-write flag at 0, a cycle with rd_stb or wr_stb high (or both) advances the pointer exactly once. With the flag at 1, only a cycle with wr_stb high advances it, and a read alone leaves X and Y unchanged.
- R6: phys_col equals cur_x when the mirror flag is 0 and equals 101 - cur_x when it is 1. It is combinational from the registered state.
- R7: bank_mask is 8'hFF for Y in 0..7 and 8'h80 (the most significant bit only) for Y=8.
- R8: ld_x loads X and ld_y loads Y on the next edge. A value above 101 (for X) or above 8 (for Y) is replaced by that maximum. In the cycle after such a load, load_err is 1. In every other cycle, load_err is 0.
- R9: A cycle with ld_x or ld_y high performs no advance. Registers that are not loaded in that cycle keep their value.
- R10: cfg_we stores cfg_vert, cfg_mirror and cfg_rmw on the edge. An advance in that same cycle still follows the old mode and the old read-modify-write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_x | input | 1 | Load column register |
| ld_x_val | input | 7 | Column load value |
| ld_y | input | 1 | Load bank register |
| ld_y_val | input | 4 | Bank load value |
| rd_stb | input | 1 | One data byte read |
| wr_stb | input | 1 | One data byte written |
| cfg_we | input | 1 | Store configuration bits |
| cfg_vert | input | 1 | 1 selects column-major order |
| cfg_mirror | input | 1 | 1 reverses column mapping |
| cfg_rmw | input | 1 | 1 makes reads non-advancing |
| cur_x | output | 7 | Logical column address |
| cur_y | output | 4 | Bank address |
| phys_col | output | 7 | Physical column index |
| bank_mask | output | 8 | Valid data bits in the current bank |
| load_err | output | 1 | Previous load was clamped |

## Verification
The X and Y registers and load_err all change on the first edge after a strobe, load or configuration write, so their new values are due one cycle later. phys_col and bank_mask follow in the same cycle as the registers they depend on. The bench drives inputs on the falling edge and updates its own model for the next rising edge. On the following falling edge it compares every output, so each result is checked exactly one edge after its stimulus.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
    typedef enum logic [0:0] {
        ST_HORIZ = 1'b0,
        ST_VERT  = 1'b1
    } scan_state_t;
endpackage

// File: rtl/disp_addr_mode.sv
module disp_addr_mode
    import disp_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_vert,
    input  logic cfg_mirror,
    input  logic cfg_rmw,
    output logic vert,
    output logic mirror,
    output logic rmw
);
    scan_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HORIZ: if (cfg_we && cfg_vert)  state_d = ST_VERT;   // HORIZ_TO_VERT
            ST_VERT:  if (cfg_we && !cfg_vert) state_d = ST_HORIZ;  // VERT_TO_HORIZ
            default:  state_d = ST_HORIZ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HORIZ;
            mirror  <= 1'b0;
            rmw     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_we) begin
                mirror <= cfg_mirror;
                rmw    <= cfg_rmw;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_VERT: vert = 1'b1;
            default: vert = 1'b0;
        endcase
    end

    p_mode_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (vert == $past(cfg_vert)) && (rmw == $past(cfg_rmw)));
endmodule

// File: rtl/disp_addr_step.sv
module disp_addr_step #(
    parameter int XW    = 7,
    parameter int YW    = 4,
    parameter int X_MAX = 101,
    parameter int Y_MAX = 8
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          vert,
    output logic [XW-1:0] nx,
    output logic [YW-1:0] ny
);
    logic x_last, y_last;
    assign x_last = (x == XW'(X_MAX));
    assign y_last = (y == YW'(Y_MAX));

    always_comb begin
        nx = x;
        ny = y;
        if (x_last && y_last) begin
            nx = '0;
            ny = '0;
        end else if (vert) begin
            if (y_last) begin
                ny = '0;
                nx = x + XW'(1);
            end else begin
                ny = y + YW'(1);
            end
        end else begin
            if (x_last) begin
                nx = '0;
                ny = y + YW'(1);
            end else begin
                nx = x + XW'(1);
            end
        end
    end
endmodule

// File: rtl/disp_addr_map.sv
module disp_addr_map #(
    parameter int XW        = 7,
    parameter int YW        = 4,
    parameter int X_MAX     = 101,
    parameter int Y_MAX     = 8,
    parameter int BANK_W    = 8,
    parameter int LAST_BITS = 1
) (
    input  logic [XW-1:0]     x,
    input  logic [YW-1:0]     y,
    input  logic              mirror,
    output logic [XW-1:0]     col,
    output logic [BANK_W-1:0] mask
);
    localparam logic [BANK_W-1:0] LAST_MASK = ~({BANK_W{1'b1}} >> LAST_BITS);

    assign col  = mirror ? (XW'(X_MAX) - x) : x;
    assign mask = (y == YW'(Y_MAX)) ? LAST_MASK : {BANK_W{1'b1}};

    always_comb begin
        if (x <= XW'(X_MAX)) begin
            p_col_range_r6: assert (col <= XW'(X_MAX));
        end
    end
endmodule

// File: rtl/disp_addr_ptr.sv
module disp_addr_ptr
    import disp_addr_pkg::*;
#(
    parameter int COLS      = 102,
    parameter int BANKS     = 9,
    parameter int BANK_W    = 8,
    parameter int LAST_BITS = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_x,
    input  logic [$clog2(COLS)-1:0]     ld_x_val,
    input  logic                        ld_y,
    input  logic [$clog2(BANKS+1)-1:0]  ld_y_val,
    input  logic                        rd_stb,
    input  logic                        wr_stb,
    input  logic                        cfg_we,
    input  logic                        cfg_vert,
    input  logic                        cfg_mirror,
    input  logic                        cfg_rmw,
    output logic [$clog2(COLS)-1:0]     cur_x,
    output logic [$clog2(BANKS+1)-1:0]  cur_y,
    output logic [$clog2(COLS)-1:0]     phys_col,
    output logic [BANK_W-1:0]           bank_mask,
    output logic                        load_err
);
    localparam int XW    = $clog2(COLS);
    localparam int YW    = $clog2(BANKS + 1);
    localparam int X_MAX = COLS - 1;
    localparam int Y_MAX = BANKS - 1;

    logic          vert, mirror, rmw;
    logic          adv, ld_any, x_over, y_over;
    logic [XW-1:0] nx;
    logic [YW-1:0] ny;

    disp_addr_mode u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vert(cfg_vert),
        .cfg_mirror(cfg_mirror), .cfg_rmw(cfg_rmw),
        .vert(vert), .mirror(mirror), .rmw(rmw)
    );

    disp_addr_step #(.XW(XW), .YW(YW), .X_MAX(X_MAX), .Y_MAX(Y_MAX)) u_step (
        .x(cur_x), .y(cur_y), .vert(vert), .nx(nx), .ny(ny)
    );

    disp_addr_map #(.XW(XW), .YW(YW), .X_MAX(X_MAX), .Y_MAX(Y_MAX),
                    .BANK_W(BANK_W), .LAST_BITS(LAST_BITS)) u_map (
        .x(cur_x), .y(cur_y), .mirror(mirror), .col(phys_col), .mask(bank_mask)
    );

    assign ld_any = ld_x || ld_y;
    assign adv    = !ld_any && (wr_stb || (rd_stb && !rmw));
    assign x_over = ld_x && (ld_x_val > XW'(X_MAX));
    assign y_over = ld_y && (ld_y_val > YW'(Y_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x    <= '0;
            cur_y    <= '0;
            load_err <= 1'b0;
        end else begin
            load_err <= x_over || y_over;
            if (ld_x) cur_x <= x_over ? XW'(X_MAX) : ld_x_val;
            if (ld_y) cur_y <= y_over ? YW'(Y_MAX) : ld_y_val;
            if (adv) begin
                cur_x <= nx;
                cur_y <= ny;
            end
        end
    end

    p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_x <= XW'(X_MAX)) && (cur_y <= YW'(Y_MAX)));

    p_horiz_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ld_any && !vert && cur_x != XW'(X_MAX))
        |=> (cur_x == $past(cur_x) + XW'(1)) && $stable(cur_y));

    p_vert_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ld_any && vert && cur_y != YW'(Y_MAX))
        |=> (cur_y == $past(cur_y) + YW'(1)) && $stable(cur_x));

    p_last_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ld_any && cur_x == XW'(X_MAX) && cur_y == YW'(Y_MAX))
        |=> (cur_x == '0) && (cur_y == '0));

    p_rmw_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && rmw && !ld_any && !cfg_we)
        |=> $stable(cur_x) && $stable(cur_y));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_x && !ld_y && (wr_stb || rd_stb)) |=> $stable(cur_y));

    p_clamp_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_x && ld_x_val > XW'(X_MAX)) |=> load_err && (cur_x == XW'(X_MAX)));
endmodule

// File: tb/disp_addr_ptr_bench.sv
module disp_addr_ptr_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_x = 0, ld_y = 0, rd_stb = 0, wr_stb = 0;
    logic cfg_we = 0, cfg_vert = 0, cfg_mirror = 0, cfg_rmw = 0;
    logic [6:0] ld_x_val = 0;
    logic [3:0] ld_y_val = 0;
    logic [6:0] cur_x, phys_col;
    logic [3:0] cur_y;
    logic [7:0] bank_mask;
    logic       load_err;

    int checks = 0, failures = 0;
    int mx = 0, my = 0;
    bit mv = 0, mm = 0, mr = 0, merr = 0;

    always #2 clk = ~clk;

    disp_addr_ptr u_disp_addr_ptr (
        .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .ld_x_val(ld_x_val),
        .ld_y(ld_y), .ld_y_val(ld_y_val), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .cfg_we(cfg_we), .cfg_vert(cfg_vert), .cfg_mirror(cfg_mirror),
        .cfg_rmw(cfg_rmw), .cur_x(cur_x), .cur_y(cur_y), .phys_col(phys_col),
        .bank_mask(bank_mask), .load_err(load_err)
    );

    function automatic int exp_col(int x, bit m);
        return m ? (101 - x) : x;
    endfunction

    function automatic int exp_mask(int y);
        return (y == 8) ? 8'h80 : 8'hFF;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "cur_x", int'(cur_x), mx);
        chk(tag, "cur_y", int'(cur_y), my);
        chk(tag, "phys_col", int'(phys_col), exp_col(mx, mm));
        chk(tag, "bank_mask", int'(bank_mask), exp_mask(my));
        chk(tag, "load_err", int'(load_err), int'(merr));
    endtask

    // Drive one cycle at the falling edge, update the model, compare one edge later.
    task automatic cyc(bit lx, int vx, bit ly, int vy, bit rd, bit wr,
                       bit cw, bit cv, bit cm, bit cr, string tag);
        bit adv;
        ld_x = lx; ld_x_val = 7'(vx); ld_y = ly; ld_y_val = 4'(vy);
        rd_stb = rd; wr_stb = wr; cfg_we = cw; cfg_vert = cv;
        cfg_mirror = cm; cfg_rmw = cr;
        adv  = !(lx || ly) && (wr || (rd && !mr));
        merr = (lx && vx > 101) || (ly && vy > 8);
        if (lx) mx = (vx > 101) ? 101 : vx;
        if (ly) my = (vy > 8) ? 8 : vy;
        if (adv) begin
            if (mx == 101 && my == 8) begin mx = 0; my = 0; end
            else if (mv) begin
                if (my == 8) begin my = 0; mx++; end else my++;
            end else begin
                if (mx == 101) begin mx = 0; my++; end else mx++;
            end
        end
        if (cw) begin mv = cv; mm = cm; mr = cr; end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic cfg(bit v, bit m, bit r, string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, v, m, r, tag);
    endtask

    task automatic wr(string tag);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, tag);
    endtask

    task automatic rd(string tag);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic ldxy(int x, int y, string tag);
        cyc(1, x, 1, y, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // R2: row-major stepping and X wrap
        ldxy(100, 0, "R8");
        wr("R2"); wr("R2"); wr("R2");
        // R4: final address wrap in row-major order
        ldxy(101, 8, "R7");
        wr("R4");
        // R3: column-major stepping and Y wrap
        cfg(1, 0, 0, "R10");
        ldxy(5, 7, "R8");
        wr("R3"); wr("R3"); wr("R3");
        ldxy(101, 8, "R8");
        wr("R4");
        // R5: read-modify-write flag
        cfg(0, 0, 1, "R10");
        ldxy(10, 2, "R8");
        rd("R5"); rd("R5"); wr("R5");
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5");
        cfg(0, 0, 0, "R10");
        rd("R5");
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5");
        // R6: mirrored column mapping
        cfg(0, 1, 0, "R6");
        ldxy(0, 3, "R6");
        ldxy(101, 3, "R6");
        ldxy(40, 8, "R7");
        cfg(0, 0, 0, "R6");
        // R8: clamping and error flag
        cyc(1, 120, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 1, 15, 0, 0, 0, 0, 0, 0, "R8");
        idle("R8");
        // R9: load beats advance; the other register holds
        ldxy(20, 4, "R9");
        cyc(1, 50, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
        cyc(0, 0, 1, 6, 1, 0, 0, 0, 0, 0, "R9");
        // R10: advance in the cfg_we cycle uses the old mode
        ldxy(101, 2, "R10");
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 1, "R10");
        wr("R10");
        rd("R10");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R10");

        // Random mix, model-checked
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit lx, ly, cw;
            r  = int'($urandom_range(0, 99));
            lx = (r < 6);
            ly = (r >= 4 && r < 9);
            cw = (r >= 95);
            cyc(lx, int'($urandom_range(0, 127)), ly, int'($urandom_range(0, 15)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                cw, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), "R2/R3 random");
        end

        // Reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mx = 0; my = 0; mv = 0; mm = 0; mr = 0; merr = 0;
        compare("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule